// File: doc/BRIEF.md
# Bit-Clearing Flash Page Buffer

This block holds one page of data on its way into a flash array. A bus master writes full 32-bit words into it. A write cannot replace the stored word. It stores the bitwise AND of the old word and the new data, so a bit can only go from one to zero. The only way back to one is the clear input, which returns every word to all-ones in a single cycle. This lets software program single words in place. It loads the buffer with the existing page AND the new data, and only words that were erased in the array can take a new value.

The word address of a write is split in two. The low bits pick a word inside the buffer. The high bits are captured as the target page number, and a separate flag records whether the write was aimed at the user page. A read port with one cycle of latency lets a page-program engine fetch the words. Writing a page out does not clear the buffer; it keeps its contents until the clear input is pulsed. Each legal write holds the bus for a fixed number of wait states. A write with any byte strobe low is refused and reported with an error pulse.

Top module: `cbpb_top`

## Requirements
- R1: After reset every word reads 0xFFFFFFFF, `page_num` is 0, `page_user` is 0, and `wr_ack` and `wr_err` are low.
- R2: A legal write stores the bitwise AND of the word held at the addressed location and `wr_data`.
- R3: A write never changes a stored zero bit to one, even when `wr_data` has that bit at one.
- R4: A one-cycle pulse on `clr_req` returns every word to 0xFFFFFFFF by the next clock edge and leaves `page_num` and `page_user` unchanged.
- R5: The buffer keeps its contents through reads, idle cycles and refused writes, until the next clear.
- R6: A write whose `wr_strb` is not 4'b1111 gives a single-cycle `wr_err` pulse in the cycle after it is first sampled, with no `wr_ack`. It leaves the buffer, `page_num` and `page_user` unchanged.
- R7: With WAIT_ST = 4, a legal write gets a single-cycle `wr_ack` in the fifth cycle of the request, which is 4 wait states. The word is visible on the read port from the next edge on.
- R8: The word index is `wr_addr[IDX_W-1:0]` and the page number `wr_addr[ADDR_W-1:IDX_W]`, captured on a legal write. With DEPTH = 128, word address 130 stores into word 2 and sets `page_num` to 1.
- R9: `wr_user` is captured into `page_user` on each legal write.
- R10: `rd_data` shows the word at `rd_addr` one clock edge after `rd_addr` is applied.
- R11: A clear sampled on the same edge that a write completes still lets that write land, merged with all-ones, while every other word becomes 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request, held until `wr_ack` or `wr_err` |
| wr_addr | input | ADDR_W | Word address (page number above, word index below) |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte strobes; only 4'b1111 is legal |
| wr_user | input | 1 | Write targets the user page |
| wr_ack | output | 1 | Write complete, one cycle |
| wr_err | output | 1 | Sub-word write refused, one cycle |
| clr_req | input | 1 | Return all words to all-ones |
| rd_addr | input | IDX_W | Read word index |
| rd_data | output | 32 | Read word, one cycle latency |
| page_num | output | ADDR_W-IDX_W | Captured page number |
| page_user | output | 1 | Captured user-page flag |

## Verification
Writing a value over an all-ones word shows that a fresh location takes the data as written. A second write with different ones and zeros, and a write of all-ones over a partly zero word, show that the merge is an AND and not a store or an OR. Partial strobes are tried against a word that is already partly zero, which shows that a refused write touches nothing. A clear timed to meet the last wait state shows whether the finishing write or the clear wins on that word.

// File: rtl/cbpb_pkg.sv
package cbpb_pkg;
  localparam int WORD_W = 32;
  localparam int STRB_W = WORD_W / 8;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
endpackage

// File: rtl/cbpb_ctrl.sv
module cbpb_ctrl
  import cbpb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 7,
  parameter int WAIT_ST = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req,
  input  logic [ADDR_W-1:0]       addr,
  input  word_t                   data,
  input  logic [STRB_W-1:0]       strb,
  input  logic                    user,
  output logic                    ack,
  output logic                    err,
  output logic                    commit,
  output logic [IDX_W-1:0]        rmw_idx,
  output word_t                   data_q,
  output logic [ADDR_W-IDX_W-1:0] page_q,
  output logic                    user_q
);
  localparam int CNT_W = $clog2(WAIT_ST + 1);
  localparam logic [STRB_W-1:0] FULL = '1;

  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx_q;
  logic             take, take_ok, take_bad;

  assign take     = (st == ST_IDLE) && req && !ack && !err;
  assign take_ok  = take && (strb == FULL);
  assign take_bad = take && (strb != FULL);
  assign commit   = (st == ST_WAIT) && (cnt == CNT_W'(WAIT_ST - 1));
  // Port A reads the incoming address while idle so the old word is ready early.
  assign rmw_idx  = (st == ST_IDLE) ? addr[IDX_W-1:0] : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      ack    <= 1'b0;
      err    <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
      page_q <= '0;
      user_q <= 1'b0;
    end else begin
      ack <= 1'b0;
      err <= take_bad;
      if (take_ok) begin
        st     <= ST_WAIT;
        cnt    <= CNT_W'(1);
        idx_q  <= addr[IDX_W-1:0];
        data_q <= data;
        page_q <= addr[ADDR_W-1:IDX_W];
        user_q <= user;
      end else if (commit) begin
        st  <= ST_IDLE;
        ack <= 1'b1;
      end else if (st == ST_WAIT) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);
  // R7
  ack_after_commit_chk: assert property (@(posedge clk) disable iff (rst) commit |=> ack);
  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst) err |=> !err);
  // R6
  err_keeps_page_chk: assert property (@(posedge clk) disable iff (rst)
    take_bad |=> (err && !ack && $stable(page_q) && $stable(user_q)));
  // R8
  page_capture_chk: assert property (@(posedge clk) disable iff (rst)
    take_ok |=> (page_q == $past(addr[ADDR_W-1:IDX_W])));
endmodule

// File: rtl/cbpb_mem.sv
module cbpb_mem
  import cbpb_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] a_idx,
  input  word_t            a_wdat,
  output word_t            a_q,
  input  logic [IDX_W-1:0] b_idx,
  output word_t            b_q
);
  word_t ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[a_idx] <= a_wdat;
    a_q <= ram[a_idx];
  end

  always_ff @(posedge clk) begin
    b_q <= ram[b_idx];
  end
endmodule

// File: rtl/cbpb_valid.sv
module cbpb_valid #(
  parameter int DEPTH = 128,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             set,
  input  logic [IDX_W-1:0] set_idx,
  output logic             set_vld,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld_q
);
  logic [DEPTH-1:0] vld;

  assign set_vld = vld[set_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= vld[rd_idx];
      if (clr) vld <= '0;
      if (set) vld[set_idx] <= 1'b1;
    end
  end

  // R4
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> (vld == '0));
  // R11
  clear_keeps_write_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && set) |=> ($countones(vld) == 1));
endmodule

// File: rtl/cbpb_top.sv
module cbpb_top
  import cbpb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DEPTH   = 128,
  parameter int WAIT_ST = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PAGE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_strb,
  input  logic              wr_user,
  output logic              wr_ack,
  output logic              wr_err,
  input  logic              clr_req,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [31:0]       rd_data,
  output logic [PAGE_W-1:0] page_num,
  output logic              page_user
);
  logic             commit, rmw_vld, rd_vld_q;
  logic [IDX_W-1:0] rmw_idx;
  word_t            data_q, old_q, b_q, merged;

  cbpb_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAIT_ST(WAIT_ST)) u_ctrl (
    .clk(clk), .rst(rst), .req(wr_req), .addr(wr_addr), .data(wr_data),
    .strb(wr_strb), .user(wr_user), .ack(wr_ack), .err(wr_err),
    .commit(commit), .rmw_idx(rmw_idx), .data_q(data_q),
    .page_q(page_num), .user_q(page_user)
  );

  cbpb_valid #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_valid (
    .clk(clk), .rst(rst), .clr(clr_req), .set(commit), .set_idx(rmw_idx),
    .set_vld(rmw_vld), .rd_idx(rd_addr), .rd_vld_q(rd_vld_q)
  );

  // A word not written since the last clear counts as all-ones.
  assign merged = ((rmw_vld && !clr_req) ? old_q : '1) & data_q;

  cbpb_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .we(commit), .a_idx(rmw_idx), .a_wdat(merged), .a_q(old_q),
    .b_idx(rd_addr), .b_q(b_q)
  );

  assign rd_data = rd_vld_q ? b_q : '1;

  initial begin
    depth_pow2_chk: assert ((1 << IDX_W) == DEPTH && WAIT_ST >= 2);
  end

  // R6
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (rst) !(wr_ack && wr_err));
  // R3
  no_set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && rmw_vld && !clr_req) |-> ((merged & ~old_q) == '0));
endmodule

// File: tb/cbpb_top_tb.sv
module cbpb_top_tb;
  localparam int ADDR_W = 16;
  localparam int DEPTH  = 128;
  localparam int IDX_W  = 7;
  localparam int PAGE_W = ADDR_W - IDX_W;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_req = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [3:0]        wr_strb = '0;
  logic              wr_user = 1'b0;
  logic              wr_ack, wr_err;
  logic              clr_req = 1'b0;
  logic [IDX_W-1:0]  rd_addr = '0;
  logic [31:0]       rd_data;
  logic [PAGE_W-1:0] page_num;
  logic              page_user;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cbpb_top #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .WAIT_ST(4)) u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] s,
                          input logic u, output int cyc, output bit acked, output bit erred);
    @(negedge clk);
    wr_req = 1'b1; wr_addr = a; wr_data = d; wr_strb = s; wr_user = u;
    cyc = 0; acked = 1'b0; erred = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      if (wr_ack) acked = 1'b1;
      if (wr_err) erred = 1'b1;
      if (acked || erred) break;
    end
    wr_req = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic read_word(input logic [IDX_W-1:0] idx, output logic [31:0] d);
    @(negedge clk); rd_addr = idx;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(!wr_ack && !wr_err, "R1 handshake idle", {30'd0, wr_ack, wr_err}, 32'd0);
    check(page_num == '0 && !page_user, "R1 page", {22'd0, page_num, page_user}, 32'd0);
    read_word(7'd0, d);   check(d == ONES, "R1 word0", d, ONES);
    read_word(7'd127, d); check(d == ONES, "R1 word127", d, ONES);
  endtask

  task automatic t_merge();
    int c; bit a, e; logic [31:0] d;
    do_write(16'd130, 32'hF0F0_1234, 4'hF, 1'b0, c, a, e);
    check(a && !e && c == 4, "R7 ack after 4 wait states", c, 4);
    check(page_num == 9'd1, "R8 page from addr 130", page_num, 1);
    read_word(7'd2, d); check(d == 32'hF0F0_1234, "R8 word2 from addr 130", d, 32'hF0F0_1234);
    read_word(7'd1, d); check(d == ONES, "R8 word1 untouched", d, ONES);
    do_write(16'd2, 32'h0FF0_FFFF, 4'hF, 1'b0, c, a, e);
    check(page_num == 9'd0, "R8 page 0", page_num, 0);
    read_word(7'd2, d); check(d == 32'h00F0_1234, "R2 AND merge", d, 32'h00F0_1234);
  endtask

  task automatic t_noset();
    int c; bit a, e; logic [31:0] d;
    do_write(16'd2, ONES, 4'hF, 1'b0, c, a, e);
    read_word(7'd2, d); check(d == 32'h00F0_1234, "R3 ones cannot set bits", d, 32'h00F0_1234);
  endtask

  task automatic t_user();
    int c; bit a, e; logic [31:0] d;
    do_write(16'h0285, 32'h1234_5678, 4'hF, 1'b1, c, a, e);
    check(page_user == 1'b1, "R9 user flag set", page_user, 1);
    check(page_num == 9'd5, "R8 page 5", page_num, 5);
    do_write(16'h0005, 32'hFFFF_FF00, 4'hF, 1'b0, c, a, e);
    check(page_user == 1'b0, "R9 user flag cleared", page_user, 0);
    read_word(7'd5, d); check(d == 32'h1234_5600, "R2 second merge word5", d, 32'h1234_5600);
  endtask

  task automatic t_suberr();
    int c; bit a, e; logic [31:0] d;
    do_write(16'h0182, 32'h0000_0000, 4'b0011, 1'b1, c, a, e);
    check(e && !a && c == 1, "R6 error pulse next cycle", {c[29:0], a, e}, {30'd1, 1'b0, 1'b1});
    check(!wr_err, "R6 error one cycle", wr_err, 0);
    check(page_num == 9'd0 && !page_user, "R6 page kept", {22'd0, page_num, page_user}, 32'd0);
    read_word(7'd2, d); check(d == 32'h00F0_1234, "R6 word unchanged", d, 32'h00F0_1234);
    do_write(16'h0005, 32'h0, 4'b1110, 1'b0, c, a, e);
    read_word(7'd5, d); check(d == 32'h1234_5600, "R6 3-byte write refused", d, 32'h1234_5600);
  endtask

  task automatic t_persist();
    logic [31:0] d;
    repeat (30) @(posedge clk);
    read_word(7'd5, d); check(d == 32'h1234_5600, "R5 word5 kept", d, 32'h1234_5600);
    read_word(7'd2, d); check(d == 32'h00F0_1234, "R10 one-edge read of word2", d, 32'h00F0_1234);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    check(page_num == 9'd0, "R4 page kept", page_num, 0);
    read_word(7'd2, d); check(d == ONES, "R4 word2 cleared", d, ONES);
    read_word(7'd5, d); check(d == ONES, "R4 word5 cleared", d, ONES);
  endtask

  task automatic t_clr_commit();
    int c; bit a, e; logic [31:0] d;
    do_write(16'd9, 32'h0000_0000, 4'hF, 1'b0, c, a, e);
    do_write(16'd4, 32'h0000_FFFF, 4'hF, 1'b0, c, a, e);
    @(negedge clk);
    wr_req = 1'b1; wr_addr = 16'd9; wr_data = 32'hA5A5_A5A5; wr_strb = 4'hF;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk); clr_req = 1'b1;
    @(posedge clk); @(negedge clk);
    clr_req = 1'b0;
    check(wr_ack, "R11 write completes with clear", wr_ack, 1);
    wr_req = 1'b0;
    @(posedge clk);
    read_word(7'd9, d); check(d == 32'hA5A5_A5A5, "R11 write lands on ones", d, 32'hA5A5_A5A5);
    read_word(7'd4, d); check(d == ONES, "R11 other word cleared", d, ONES);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_merge();
    t_noset();
    t_user();
    t_suberr();
    t_persist();
    t_clear();
    t_clr_commit();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule